// File: doc/BRIEF.md
# Triangular Bitstream Smoothing Filter

This block takes a one-bit density-modulated audio stream, one bit per sample strobe, and turns it into a signed multi-bit value for a downstream requantizer and remodulator. Each incoming bit counts as +1 when it is a one and -1 when it is a zero. The fifteen most recent values are weighted by a symmetric triangle of small integers: 1 rising to 8 at the centre tap and back down to 1. The sum is registered. Because the weights add up to 64, a stream of all ones gives +64 and a stream of all zeros gives -64.

No weight uses a multiplier. Each one is built from the shifted and signed digits of its minimal signed-digit (non-adjacent) representation. A stereo system places one instance per channel, and the two instances share no state.

A mode input selects the path. When the mode input is high, the filtered value is produced. When it is low, the stream bypasses the filter: the bit appears unchanged on a separate one-bit output and the multi-bit output reads zero. The delay line keeps shifting in both modes, so a return to filtering continues from the true recent history.

Top module: `tri_bitstream_fir`

## Requirements
- R1: While `rst` is high at a clock edge, `y_out` becomes 0, `y_vld` becomes 0 and `bit_out` becomes 0. The 14-entry history, indexed from 0 for the most recent bit, is loaded with ones at even positions and zeros at odd positions.
- R2: `y_vld` is high in exactly the cycle after each cycle in which `smp_en` was high, and low otherwise.
- R3: In filter mode (`filt_mode` = 1), the edge that takes a sample loads `y_out` with sum over k = 0..14 of w(k)*s(x[k]). Here x[0] is the bit taken at that edge and x[k] is the bit taken k samples earlier. s(1) = +1 and s(0) = -1. w(k) = k+1 for k <= 7 and w(k) = 15-k for k > 7.
- R4: After 15 consecutive samples of ones, `y_out` is +64. After 15 consecutive samples of zeros, it is -64.
- R5: In cycles without `smp_en`, `y_out` and `bit_out` hold their values.
- R6: A single one within a stream of zeros makes `y_out` step through -64 + 2*w(k) on the 15 samples k = 0..14 that follow it, with the one taken at k = 0.
- R7: In bypass mode (`filt_mode` = 0), a sample loads `bit_out` with the input bit and `y_out` with 0. In filter mode, a sample loads `bit_out` with 0.
- R8: The history shifts on every sample in both modes. The first filtered output after bypass therefore includes the bits taken during bypass.
- R9: `y_out` always stays within [-64, +64]. After a filtered sample it is even.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample strobe; takes `bit_in` |
| bit_in | input | 1 | Incoming stream bit |
| filt_mode | input | 1 | 1 = filter, 0 = transparent bypass |
| y_out | output | 8 | Signed filtered value (two's complement) |
| y_vld | output | 1 | High for one cycle after each sample |
| bit_out | output | 1 | Forwarded bit in bypass mode, else 0 |

## Verification
A wrong history bit shows at the ports on the very next filtered sample. The error is an offset of twice that tap's weight, and it stays in the result until the bit has moved through all fifteen taps. A wrong weight or signed digit gives a wrong value for specific bit patterns, so random streams find it quickly, and the impulse sequence names the faulty tap directly. Mode and strobe faults show up in the first cycle after the strobe, on `y_vld`, `bit_out` or a zeroed `y_out`.

// File: rtl/tri_bitstream_fir.sv
module tri_bitstream_fir #(
  parameter int TAPS = 15,
  parameter int OW   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_en,
  input  logic                 bit_in,
  input  logic                 filt_mode,
  output logic signed [OW-1:0] y_out,
  output logic                 y_vld,
  output logic                 bit_out
);

  localparam int MID  = (TAPS - 1) / 2;
  localparam int PEAK = (MID + 1) * (MID + 1);
  localparam int HL   = TAPS - 1;

  localparam logic signed [OW-1:0] POS = {{(OW-1){1'b0}}, 1'b1};
  localparam logic signed [OW-1:0] NEG = '1;

  function automatic int tri_w(input int k);
    return (k <= MID) ? k + 1 : TAPS - k;
  endfunction

  function automatic logic [HL-1:0] rst_pat();
    logic [HL-1:0] p;
    for (int i = 0; i < HL; i++) p[i] = (i % 2 == 0);
    return p;
  endfunction

  function automatic logic signed [OW-1:0] csd_mul(input logic signed [OW-1:0] v, input int c);
    logic signed [OW-1:0] acc;
    int r;
    acc = '0;
    r = c;
    for (int i = 0; i < OW; i++) begin
      if (r % 2 != 0) begin
        if (r % 4 == 3) begin
          acc = acc - (v <<< i);
          r = r + 1;
        end else begin
          acc = acc + (v <<< i);
          r = r - 1;
        end
      end
      r = r / 2;
    end
    return acc;
  endfunction

  logic [HL-1:0]        hist;
  logic [TAPS-1:0]      win;
  logic signed [OW-1:0] term [TAPS];
  logic signed [OW-1:0] acc_sum;

  assign win = {hist, bit_in};

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign term[g] = csd_mul(win[g] ? POS : NEG, tri_w(g));
  end

  always_comb begin
    acc_sum = '0;
    for (int i = 0; i < TAPS; i++) acc_sum = acc_sum + term[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist    <= rst_pat();
      y_out   <= '0;
      y_vld   <= 1'b0;
      bit_out <= 1'b0;
    end else begin
      y_vld <= smp_en;
      if (smp_en) begin
        hist    <= win[HL-1:0];
        y_out   <= filt_mode ? acc_sum : '0;
        bit_out <= filt_mode ? 1'b0 : bit_in;
      end
    end
  end

  AST_RESET: assert property (@(posedge clk) rst |=> (y_out == 0 && !y_vld && !bit_out)); // R1
  AST_VLD_ON: assert property (@(posedge clk) disable iff (rst) smp_en |=> y_vld); // R2
  AST_VLD_OFF: assert property (@(posedge clk) disable iff (rst) !smp_en |=> !y_vld); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (rst) !smp_en |=> ($stable(y_out) && $stable(bit_out))); // R5
  AST_BYPASS: assert property (@(posedge clk) disable iff (rst) (smp_en && !filt_mode) |=> (y_out == 0 && bit_out == $past(bit_in))); // R7
  AST_FILT_BIT: assert property (@(posedge clk) disable iff (rst) (smp_en && filt_mode) |=> !bit_out); // R7
  AST_EVEN: assert property (@(posedge clk) disable iff (rst) (smp_en && filt_mode) |=> !y_out[0]); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (y_out <= PEAK && y_out >= -PEAK)); // R9

endmodule

// File: tb/test_tri_bitstream_fir.sv
`timescale 1ns/1ps
module test_tri_bitstream_fir;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_en = 1'b0;
  logic bit_in = 1'b0;
  logic filt_mode = 1'b1;
  logic signed [7:0] y_out;
  logic y_vld;
  logic bit_out;

  int n_chk = 0;
  int n_bad = 0;
  bit hist [15];
  int exp_y = 0;
  bit exp_b = 1'b0;

  always #2 clk = ~clk;

  tri_bitstream_fir i_tri_bitstream_fir (
    .clk(clk), .rst(rst), .smp_en(smp_en), .bit_in(bit_in),
    .filt_mode(filt_mode), .y_out(y_out), .y_vld(y_vld), .bit_out(bit_out)
  );

  function automatic int triw(input int k);
    return (k < 8) ? k + 1 : 15 - k;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 15; k++) hist[k] = (k < 14) && (k % 2 == 0);
    exp_y = 0;
    exp_b = 1'b0;
  endtask

  task automatic step(input bit en, input bit b, input bit m);
    smp_en = en; bit_in = b; filt_mode = m;
    @(posedge clk);
    @(negedge clk);
    if (en) begin
      for (int k = 14; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = b;
      if (m) begin
        exp_y = 0;
        for (int k = 0; k < 15; k++) exp_y += triw(k) * (hist[k] ? 1 : -1);
        exp_b = 1'b0;
      end else begin
        exp_y = 0;
        exp_b = b;
      end
    end
    check("R2 vld", int'(y_vld), int'(en));
    check(!en ? "R5 hold" : (m ? "R3 sum" : "R7 bypass"), int'(y_out), exp_y);
    check(m ? "R7 bit" : "R7 fwd", int'(bit_out), int'(exp_b));
    if (m && en) check("R9 even", int'(y_out) % 2, 0);
    smp_en = 1'b0;
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 y", int'(y_out), 0);
    check("R1 vld", int'(y_vld), 0);
    check("R1 bit", int'(bit_out), 0);
    rst = 1'b0;
    step(1, 0, 1);
    check("R1 history", int'(y_out), exp_y);

    for (int i = 0; i < 15; i++) step(1, 1, 1);
    check("R4 ones", int'(y_out), 64);
    step(0, 0, 1);
    check("R5 idle", int'(y_out), 64);
    for (int i = 0; i < 15; i++) step(1, 0, 1);
    check("R4 zeros", int'(y_out), -64);

    step(1, 1, 1);
    check("R6 k0", int'(y_out), -64 + 2 * triw(0));
    for (int k = 1; k < 15; k++) begin
      step(1, 0, 1);
      check("R6 impulse", int'(y_out), -64 + 2 * triw(k));
    end

    for (int i = 0; i < 14; i++) step(1, 1, 0);
    check("R7 bypass y", int'(y_out), 0);
    check("R7 bypass bit", int'(bit_out), 1);
    step(1, 1, 1);
    check("R8 resume", int'(y_out), 64);

    for (int i = 0; i < 3000; i++) begin
      bit e = ($urandom % 4) != 0;
      bit b = $urandom % 2;
      bit m = ($urandom % 8) != 0;
      step(e, b, m);
    end

    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 re-reset", int'(y_out), 0);
    model_reset();
    rst = 1'b0;
    step(1, 1, 1);
    finish_up();
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule